// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM With Lane Writes

This block is a single-port synchronous static memory. Each word is 36 bits wide and is split into four 9-bit lanes. A lane holds eight data bits and one parity bit. The address, the write data and every control input are captured on the rising clock edge. The read path has no output register, so a read's data appears in the cycle right after the edge that captured its address. A burst sequencer outside the block supplies the address on every cycle. The array depth is a parameter and stays small for simulation.

A cycle takes effect only when all three chip selects are in their active state. A write can cover any set of lanes. Each lane is picked by its own enable, and those enables count only while the lane-write strobe is low. A low global write stores all four lanes whatever the lane enables say. A high sleep input puts the memory in power-down. After sleep falls, three more edges pass before access resumes, and the contents are kept throughout. The output enable gates the read data bus combinationally.

Top module: `ftsram_top`

## Requirements
- R1: A read cycle is a cycle that is selected and awake and that writes no lane. After the rising edge of a read cycle, `rd_valid` is 1 and `rd_data` holds the stored word at the captured address during that same following cycle.
- R2: Word layout: lane n (n = 0..3) is data bits [8n+7:8n] plus parity bit [32+n]. With `gw_n` high and `bwe_n` low, each lane whose `lane_we_n[n]` is 0 is written.
- R3: With `gw_n` low, all four lanes are written whatever the values of `bwe_n` and `lane_we_n`.
- R4: Any lane not written in a write cycle keeps its earlier contents. This includes every lane when `bwe_n` and `gw_n` are both high, in which case the cycle is a read.
- R5: A cycle is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. A deselected cycle writes nothing and leaves `rd_valid` at 0 in the following cycle.
- R6: After the edge of a write cycle, `rd_valid` is 0 for the following cycle.
- R7: An edge with `sleep`=1 accepts no access. After `sleep` returns to 0, the next three edges still accept no access and the fourth edge does. The stored contents are kept throughout.
- R8: While `oe_n` is 1, `rd_data` is 0 at once, with no clock edge needed. `rd_valid` does not depend on `oe_n`.
- R9: After reset, `rd_valid` is 0 and the memory is awake, so the first edge after reset can already take an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address from the burst sequencer |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| bwe_n | input | 1 | Lane-write strobe, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| wr_data | input | 36 | Write word |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| rd_data | output | 36 | Flow-through read word, 0 when not driven |
| rd_valid | output | 1 | A read was taken at the last edge |

## Verification
On every cycle, the assertions check the following. A write or a deselected cycle never leaves `rd_valid` high. Sleep and a pending wake-up always stop all lane writes. A global write always reaches all four lanes. A raised `oe_n` always clears the data bus. The bench scenarios are the only way to show the data behaviour. That covers lane placement, which lanes are preserved in a partial write, contents kept across power-down, and the exact three-edge wake-up count.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
    localparam int LANES    = 4;
    localparam int LANE_DW  = 8;
    localparam int LANE_W   = LANE_DW + 1;
    localparam int WORD_W   = LANES * LANE_W;
    localparam int WAKE_CYC = 3;
    localparam int WAKE_W   = $clog2(WAKE_CYC + 1);

    typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/ftsram_ctrl.sv
module ftsram_ctrl
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              bwe_n,
    input  lane_mask_t        lane_we_n,
    input  logic              gw_n,
    input  logic              sleep,
    output lane_mask_t        lane_wr,
    output logic [ADDR_W-1:0] raddr_q,
    output logic              rvalid_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] raddr;
        logic              rvalid;
        logic [WAKE_W-1:0] wake;
    } ctrl_t;

    ctrl_t      st_d, st_q;
    logic       selected, awake, take;
    lane_mask_t mask;

    always_comb begin
        selected = !sel0_n && sel1 && !sel2_n;
        awake    = !sleep && (st_q.wake == '0);
        take     = selected && awake;
        if (!gw_n)      mask = '1;
        else if (!bwe_n) mask = ~lane_we_n;
        else            mask = '0;
        lane_wr = take ? mask : '0;

        st_d        = st_q;
        st_d.rvalid = take && (mask == '0);
        if (take) st_d.raddr = addr;
        if (sleep)                st_d.wake = WAKE_W'(WAKE_CYC);
        else if (st_q.wake != '0) st_d.wake = st_q.wake - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr_q  = st_q.raddr;
    assign rvalid_q = st_q.rvalid;

    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr != '0) |=> !rvalid_q); // R6
    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sel0_n && sel1 && !sel2_n) |=> !rvalid_q); // R5
    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rvalid_q); // R7
    AST_WAKE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wake != '0) |-> (lane_wr == '0)); // R7
    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n && lane_wr != '0) |-> (lane_wr == '1)); // R3
endmodule

// File: rtl/ftsram_lane.sv
module ftsram_lane
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdat,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdat
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdat;
    end

    assign rdat = mem_q[raddr];
endmodule

// File: rtl/ftsram_top.sv
module ftsram_top
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              bwe_n,
    input  logic [3:0]        lane_we_n,
    input  logic              gw_n,
    input  logic [35:0]       wr_data,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [35:0]       rd_data,
    output logic              rd_valid
);
    lane_mask_t        lane_wr;
    logic [ADDR_W-1:0] raddr_q;
    logic              rvalid_q;
    logic [WORD_W-1:0] word;

    ftsram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .bwe_n(bwe_n), .lane_we_n(lane_we_n), .gw_n(gw_n), .sleep(sleep),
        .lane_wr(lane_wr), .raddr_q(raddr_q), .rvalid_q(rvalid_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lin, lout;
        assign lin = {wr_data[LANES*LANE_DW+g], wr_data[g*LANE_DW +: LANE_DW]};
        ftsram_lane #(.ADDR_W(ADDR_W)) lane_i (
            .clk(clk), .we(lane_wr[g]), .waddr(addr), .wdat(lin),
            .raddr(raddr_q), .rdat(lout)
        );
        assign word[g*LANE_DW +: LANE_DW]  = lout[LANE_DW-1:0];
        assign word[LANES*LANE_DW+g]       = lout[LANE_DW];
    end

    assign rd_valid = rvalid_q;
    assign rd_data  = (!oe_n && rvalid_q) ? word : '0;

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (rd_data == '0)); // R8
endmodule

// File: tb/ftsram_top_tb_top.sv
module ftsram_top_tb_top;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic sel0_n = 1'b0, sel1 = 1'b1, sel2_n = 1'b0;
    logic bwe_n = 1'b1, gw_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [3:0] lane_we_n = 4'hF;
    logic [35:0] wr_data = '0;
    logic [35:0] rd_data;
    logic rd_valid;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [35:0] model [DEPTH];
    int  wake_left = 0;
    bit  exp_rv = 1'b0;
    int  exp_addr = 0;

    always #4 clk = ~clk;

    ftsram_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .bwe_n(bwe_n), .lane_we_n(lane_we_n), .gw_n(gw_n),
        .wr_data(wr_data), .oe_n(oe_n), .sleep(sleep),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [35:0] lane_bits(int n);
        logic [35:0] m = '0;
        for (int b = 0; b < 8; b++) m[8*n+b] = 1'b1;
        m[32+n] = 1'b1;
        return m;
    endfunction

    task automatic compare(string tag);
        logic [35:0] er;
        er = (!oe_n && exp_rv) ? model[exp_addr] : 36'h0;
        checks++;
        if (rd_valid !== exp_rv || rd_data !== er) begin
            fails++;
            $display("FAIL %s: rd_valid=%0b rd_data=%h expected rd_valid=%0b rd_data=%h",
                     tag, rd_valid, rd_data, exp_rv, er);
        end
    endtask

    task automatic cyc(string tag);
        bit sel, acc;
        logic [3:0] m;
        @(posedge clk);
        sel = !sel0_n && sel1 && !sel2_n;
        acc = sel && !sleep && wake_left == 0;
        m = !gw_n ? 4'hF : (!bwe_n ? ~lane_we_n : 4'h0);
        if (sleep) wake_left = 3;
        else if (wake_left > 0) wake_left--;
        exp_rv = acc && (m == 4'h0);
        if (acc && m == 4'h0) exp_addr = addr;
        if (acc)
            for (int n = 0; n < 4; n++)
                if (m[n]) model[addr] = (model[addr] & ~lane_bits(n)) | (wr_data & lane_bits(n));
        #1 compare(tag);
    endtask

    task automatic idle();
        bwe_n = 1'b1; gw_n = 1'b1; lane_we_n = 4'hF;
    endtask

    task automatic rd(int a, string tag);
        idle(); addr = AW'(a); cyc(tag);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #2 compare("R9 reset");
        #10 rst_n = 1'b1;
        @(negedge clk);
        // R9: first edge after reset writes at once
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(a); gw_n = 1'b0; lane_we_n = 4'hF; bwe_n = 1'b1;
            wr_data = {4'(a), 32'hA5000000 | 32'(a * 32'h01010101)};
            cyc("R3 R6 R9 fill");
        end
        for (int a = 0; a < DEPTH; a++) rd(a, "R1 readback");
        // R2 single-lane writes
        for (int n = 0; n < 4; n++) begin
            idle(); addr = AW'(n + 2); bwe_n = 1'b0;
            lane_we_n = ~(4'h1 << n); wr_data = 36'hF_DEADBEEF ^ 36'(n * 36'h111);
            cyc("R2 lane write");
            rd(n + 2, "R2 R4 lane read");
        end
        // R2 two lanes
        idle(); addr = 4'd7; bwe_n = 1'b0; lane_we_n = 4'b0101; wr_data = 36'h5_12345678;
        cyc("R2 two lanes"); rd(7, "R4 two lanes read");
        // R4 bwe_n high with lane enables low: read, no write
        idle(); addr = 4'd8; lane_we_n = 4'h0; wr_data = 36'h0;
        cyc("R4 strobe off"); rd(8, "R4 strobe off read");
        // R3 global write ignores lanes and strobe
        idle(); addr = 4'd9; gw_n = 1'b0; bwe_n = 1'b1; lane_we_n = 4'hF; wr_data = 36'hC_CAFEF00D;
        cyc("R3 global"); rd(9, "R3 global read");
        idle(); addr = 4'd10; gw_n = 1'b0; bwe_n = 1'b0; lane_we_n = 4'b1110; wr_data = 36'h3_0BADC0DE;
        cyc("R3 global over lanes"); rd(10, "R3 global read");
        // R5 deselect each enable
        for (int k = 0; k < 3; k++) begin
            idle(); addr = 4'd11; gw_n = 1'b0; wr_data = 36'h0;
            sel0_n = (k == 0); sel1 = (k != 1); sel2_n = (k == 2);
            cyc("R5 deselect write");
            idle(); cyc("R5 deselect read");
            sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
            rd(11, "R5 contents kept");
        end
        // R6 write then read same address
        idle(); addr = 4'd12; gw_n = 1'b0; wr_data = 36'h9_87654321;
        cyc("R6 write idle"); rd(12, "R1 R6 after write");
        // R7 sleep
        idle(); sleep = 1'b1; addr = 4'd12; cyc("R7 asleep read");
        gw_n = 1'b0; wr_data = 36'h0; cyc("R7 asleep write");
        sleep = 1'b0;
        cyc("R7 wake 1 write"); cyc("R7 wake 2 write"); cyc("R7 wake 3 write");
        rd(12, "R7 first access after wake");
        rd(9, "R7 contents kept");
        // R8 output enable
        rd(5, "R1 before oe");
        #1 oe_n = 1'b1; #1 compare("R8 oe high");
        #1 oe_n = 1'b0; #1 compare("R8 oe low");
        oe_n = 1'b1; rd(6, "R8 valid with oe high");
        oe_n = 1'b0; rd(6, "R8 oe restored");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule